// File: doc/BRIEF.md
# DMA Burst Address Sequencer with Window Wrap

This block produces the read and write addresses for one DMA channel over a transfer that is split into bursts whose length is a power of two. A 4-bit length code selects the burst length. Each side (source and destination) has its own step code, so its address can stay fixed or move by 1, 2 or 4 units per beat. Each side can also be told to wrap. A wrapping side goes back to its start address after the last beat of every burst, so every burst covers the same address window, for example the same group of device registers read or written once per burst.

A start strobe does three things: it loads the configuration, checks it, and reloads the counters and addresses. After that, each advance strobe moves the channel on by one beat. A one-cycle flag marks the end of each burst. A sticky flag marks the end of the whole transfer. A configuration that cannot be run raises an error flag and keeps the channel idle. The block carries no data and makes no bus requests. It only counts beats and sequences addresses.

Top module: `dma_burst_addr_gen`

## Requirements
- R1: After reset both addresses are 0, and `burst_done_o`, `xfer_done_o` and `cfg_err_o` are 0.
- R2: In the cycle after a start strobe, each address equals its base input, `burst_done_o` and `xfer_done_o` are 0, and `cfg_err_o` shows whether the configuration just loaded is invalid.
- R3: A length code from 11 to 15 is invalid. It sets `cfg_err_o`, and while the error is held, advance strobes leave both addresses unchanged.
- R4: The configuration is also invalid when the beat count is 0, when it is above 1024, or when it is not a whole multiple of the burst length 2^code. The burst length runs from 1 beat at code 0 to 1024 beats at code 10.
- R5: The step code of each side maps 0→0, 1→1, 2→2 and 3→4 address units. A side without wrap adds its step after every accepted beat, and it keeps doing so across burst boundaries.
- R6: A side with wrap enabled returns to its base address after the last beat of every burst. Inside a burst it adds its step after each beat.
- R7: `burst_done_o` is high for exactly the one cycle after an accepted beat that completes a burst. It is low at all other times.
- R8: `xfer_done_o` rises in the cycle after the final beat and stays high until the next start. Advance strobes given after that point change neither address.
- R9: A start strobe and an advance strobe in the same cycle: the start wins and the advance is discarded.
- R10: Advance strobes given after reset but before any start strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin a transfer |
| adv_i | input | 1 | One beat has completed |
| src_base_i | input | ADDR_W | Source start address |
| dst_base_i | input | ADDR_W | Destination start address |
| src_inc_i | input | 2 | Source step code |
| dst_inc_i | input | 2 | Destination step code |
| xfer_cnt_i | input | CNT_W | Total beats in the transfer |
| burst_pwr_i | input | 4 | Burst length code (length = 2^code) |
| src_wrap_i | input | 1 | Source wraps to its base every burst |
| dst_wrap_i | input | 1 | Destination wraps to its base every burst |
| src_addr_o | output | ADDR_W | Current source address |
| dst_addr_o | output | ADDR_W | Current destination address |
| burst_done_o | output | 1 | Pulse after the last beat of a burst |
| xfer_done_o | output | 1 | Transfer complete (sticky) |
| cfg_err_o | output | 1 | Loaded configuration is invalid |

## Verification
A fault in the position counter inside a burst appears in the very next cycle. Either `burst_done_o` pulses at the wrong beat, or a wrapping address returns to its base too early or too late. A fault in the count of remaining beats does not appear until the end of the transfer. At that point `xfer_done_o` rises one beat early or late, and a late rise lets an extra advance move the addresses. For this reason the directed runs compare both addresses and both flags after every beat, and they add one beat past the final one.

// File: rtl/dbag_pkg.sv
package dbag_pkg;

  localparam int unsigned PWR_W   = 4;
  localparam int unsigned MAX_PWR = 10;

  // burst length in beats for a length code; unsupported codes give 1
  function automatic int unsigned burst_len(input logic [PWR_W-1:0] pwr);
    if (int'(pwr) > int'(MAX_PWR)) return 1;
    return 32'd1 << pwr;
  endfunction

  // address step in units for a 2-bit step code
  function automatic int unsigned inc_step(input logic [1:0] code);
    unique case (code)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 4;
    endcase
  endfunction

  // invalid when code is out of range, count is 0 or too big, or not a multiple
  function automatic logic cfg_bad(input logic [PWR_W-1:0] pwr,
                                   input int unsigned      count,
                                   input int unsigned      max_count);
    int unsigned len;
    len = burst_len(pwr);
    if (int'(pwr) > int'(MAX_PWR)) return 1'b1;
    if (count == 0 || count > max_count) return 1'b1;
    return (count & (len - 1)) != 0;
  endfunction

endpackage

// File: rtl/dbag_cfg_check.sv
module dbag_cfg_check
  import dbag_pkg::*;
#(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned MAX_CNT = 1024
) (
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             err_o,
  output logic [CNT_W-1:0] len_o
);
  always_comb begin
    err_o = cfg_bad(pwr_i, int'(count_i), MAX_CNT);
    len_o = CNT_W'(burst_len(pwr_i));
  end
endmodule

// File: rtl/dbag_beat_ctr.sv
module dbag_beat_ctr #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             ok_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             adv_i,
  output logic             active_o,
  output logic             beat_evt_o,
  output logic             burst_end_o,
  output logic             burst_done_o,
  output logic             xfer_done_o
);
  logic [CNT_W-1:0] beat_idx, remain, len_q;
  logic             last_beat;

  assign beat_evt_o  = adv_i && active_o && !load_i;
  assign burst_end_o = beat_evt_o && (beat_idx == len_q - 1'b1);
  assign last_beat   = beat_evt_o && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_idx     <= '0;
      remain       <= '0;
      len_q        <= CNT_W'(1);
      active_o     <= 1'b0;
      burst_done_o <= 1'b0;
      xfer_done_o  <= 1'b0;
    end else if (load_i) begin
      beat_idx     <= '0;
      remain       <= count_i;
      len_q        <= len_i;
      active_o     <= ok_i;
      burst_done_o <= 1'b0;
      xfer_done_o  <= 1'b0;
    end else begin
      burst_done_o <= burst_end_o;
      if (beat_evt_o) begin
        beat_idx <= burst_end_o ? '0 : beat_idx + 1'b1;
        remain   <= remain - 1'b1;
        if (last_beat) begin
          active_o    <= 1'b0;
          xfer_done_o <= 1'b1;
        end
      end
    end
  end

  AST_IDX_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (beat_idx < len_q)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_o && !load_i) |=> xfer_done_o); // R8
  AST_FINAL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done_o) |-> burst_done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> !active_o); // R8
endmodule

// File: rtl/dbag_addr_side.sv
module dbag_addr_side
  import dbag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        inc_code_i,
  input  logic              wrap_i,
  input  logic              beat_i,
  input  logic              burst_end_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, step_q;
  logic              wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
      base_q <= '0;
      step_q <= '0;
      wrap_q <= 1'b0;
    end else if (load_i) begin
      addr_o <= base_i;
      base_q <= base_i;
      step_q <= ADDR_W'(inc_step(inc_code_i));
      wrap_q <= wrap_i;
    end else if (beat_i) begin
      addr_o <= (wrap_q && burst_end_i) ? base_q : addr_o + step_q;
    end
  end

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && burst_end_i && wrap_q && !load_i) |=> (addr_o == base_q)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_i && !load_i) |=> $stable(addr_o)); // R8
endmodule

// File: rtl/dma_burst_addr_gen.sv
module dma_burst_addr_gen
  import dbag_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned MAX_CNT = 1024,
  parameter int unsigned CNT_W   = $clog2(MAX_CNT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [1:0]        src_inc_i,
  input  logic [1:0]        dst_inc_i,
  input  logic [CNT_W-1:0]  xfer_cnt_i,
  input  logic [3:0]        burst_pwr_i,
  input  logic              src_wrap_i,
  input  logic              dst_wrap_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              burst_done_o,
  output logic              xfer_done_o,
  output logic              cfg_err_o
);
  localparam int unsigned SIDES = 2;

  logic             cfg_bad_w;
  logic [CNT_W-1:0] len_w;
  logic             active_w, beat_evt_w, burst_end_w;

  logic [SIDES-1:0][ADDR_W-1:0] base_a, addr_a;
  logic [SIDES-1:0][1:0]        inc_a;
  logic [SIDES-1:0]             wrap_a;

  assign base_a = {dst_base_i, src_base_i};
  assign inc_a  = {dst_inc_i, src_inc_i};
  assign wrap_a = {dst_wrap_i, src_wrap_i};

  dbag_cfg_check #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_chk (
    .pwr_i   (burst_pwr_i),
    .count_i (xfer_cnt_i),
    .err_o   (cfg_bad_w),
    .len_o   (len_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_err_o <= 1'b0;
    else if (start_i) cfg_err_o <= cfg_bad_w;
  end

  dbag_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (start_i),
    .ok_i         (!cfg_bad_w),
    .count_i      (xfer_cnt_i),
    .len_i        (len_w),
    .adv_i        (adv_i),
    .active_o     (active_w),
    .beat_evt_o   (beat_evt_w),
    .burst_end_o  (burst_end_w),
    .burst_done_o (burst_done_o),
    .xfer_done_o  (xfer_done_o)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dbag_addr_side #(.ADDR_W(ADDR_W)) u_side (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (start_i),
      .base_i      (base_a[s]),
      .inc_code_i  (inc_a[s]),
      .wrap_i      (wrap_a[s]),
      .beat_i      (beat_evt_w),
      .burst_end_i (burst_end_w),
      .addr_o      (addr_a[s])
    );
  end

  assign src_addr_o = addr_a[0];
  assign dst_addr_o = addr_a[1];

  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !active_w); // R3
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (src_addr_o == $past(src_base_i) && !burst_done_o)); // R9
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !burst_done_o); // R4
endmodule

// File: tb/tb_dma_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_burst_addr_gen;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, adv_i = 1'b0;
  logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
  logic [1:0]    src_inc_i = '0, dst_inc_i = '0;
  logic [CW-1:0] xfer_cnt_i = '0;
  logic [3:0]    burst_pwr_i = '0;
  logic          src_wrap_i = 1'b0, dst_wrap_i = 1'b0;
  logic [AW-1:0] src_addr_o, dst_addr_o;
  logic          burst_done_o, xfer_done_o, cfg_err_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  dma_burst_addr_gen dut (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] units(input logic [1:0] c);
    logic [AW-1:0] tbl [4] = '{0, 1, 2, 4};
    return tbl[c];
  endfunction

  task automatic do_start(input logic [3:0] p, input int cnt,
                          input logic [AW-1:0] sb, db, input logic [1:0] sc, dc,
                          input logic sw, dw, input logic with_adv);
    @(negedge clk);
    burst_pwr_i = p; xfer_cnt_i = CW'(cnt);
    src_base_i = sb; dst_base_i = db; src_inc_i = sc; dst_inc_i = dc;
    src_wrap_i = sw; dst_wrap_i = dw; start_i = 1'b1; adv_i = with_adv;
    @(negedge clk);
    start_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic beat();
    @(negedge clk); adv_i = 1'b1;
    @(negedge clk); adv_i = 1'b0;
  endtask

  // runs a valid transfer, checking every beat plus one extra
  task automatic run_xfer(input logic [3:0] p, input int cnt,
                          input logic [AW-1:0] sb, db, input logic [1:0] sc, dc,
                          input logic sw, dw, input string tag);
    int len = 1 << p;
    logic [AW-1:0] es, ed;
    do_start(p, cnt, sb, db, sc, dc, sw, dw, 1'b0);
    chk(src_addr_o, sb, {tag, " R2 src base"});
    chk(dst_addr_o, db, {tag, " R2 dst base"});
    chk({burst_done_o, xfer_done_o, cfg_err_o}, 3'b000, {tag, " R2 flags"});
    for (int n = 1; n <= cnt; n++) begin
      beat();
      es = sb + units(sc) * (sw ? AW'(n % len) : AW'(n));
      ed = db + units(dc) * (dw ? AW'(n % len) : AW'(n));
      chk(src_addr_o, es, {tag, sw ? " R6 src wrap" : " R5 src step"});
      chk(dst_addr_o, ed, {tag, dw ? " R6 dst wrap" : " R5 dst step"});
      chk(burst_done_o, (n % len) == 0, {tag, " R7 burst pulse"});
      chk(xfer_done_o, n == cnt, {tag, " R8 done"});
    end
    beat();
    chk(src_addr_o, es, {tag, " R8 src hold after done"});
    chk(dst_addr_o, ed, {tag, " R8 dst hold after done"});
    chk({burst_done_o, xfer_done_o}, 2'b01, {tag, " R8 flags after done"});
  endtask

  task automatic t_reset();
    chk(src_addr_o, 0, "R1 src");
    chk(dst_addr_o, 0, "R1 dst");
    chk({burst_done_o, xfer_done_o, cfg_err_o}, 0, "R1 flags");
  endtask

  task automatic t_no_start();
    beat(); beat();
    chk({src_addr_o, dst_addr_o}, 0, "R10 adv before start");
    chk({burst_done_o, xfer_done_o}, 0, "R10 flags");
  endtask

  task automatic t_bad(input logic [3:0] p, input int cnt, input string tag);
    do_start(p, cnt, 32'h100, 32'h200, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    chk(cfg_err_o, 1'b1, {tag, " err flag"});
    beat();
    chk(src_addr_o, 32'h100, {tag, " R3 src frozen"});
    chk(dst_addr_o, 32'h200, {tag, " R3 dst frozen"});
    chk({burst_done_o, xfer_done_o}, 0, {tag, " no done"});
  endtask

  task automatic t_start_wins();
    do_start(4'd1, 4, 32'h4000, 32'h5000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    beat();
    chk(src_addr_o, 32'h4001, "R9 pre-step");
    do_start(4'd1, 4, 32'h6000, 32'h7000, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1);
    chk(src_addr_o, 32'h6000, "R9 src restart no step");
    chk(dst_addr_o, 32'h7000, "R9 dst restart no step");
    chk(cfg_err_o, 1'b0, "R9 cfg ok");
    beat();
    chk(src_addr_o, 32'h6002, "R9 first beat after restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_no_start();
    run_xfer(4'd2, 8, 32'h1000, 32'h2000, 2'd1, 2'd3, 1'b0, 1'b0, "nowrap");
    run_xfer(4'd1, 6, 32'h3000, 32'h8000, 2'd2, 2'd0, 1'b1, 1'b0, "srcwrap");
    run_xfer(4'd0, 3, 32'h10, 32'h20, 2'd3, 2'd1, 1'b1, 1'b1, "len1");
    run_xfer(4'd3, 16, 32'hFFFF_FFF8, 32'h40, 2'd1, 2'd2, 1'b0, 1'b1, "dstwrap");
    run_xfer(4'd10, 1024, 32'hA000, 32'hB000, 2'd1, 2'd3, 1'b1, 1'b0, "max");
    t_bad(4'd11, 2048 >> 1, "R3 code11");
    t_bad(4'd15, 4, "R3 code15");
    t_bad(4'd2, 6, "R4 not multiple");
    t_bad(4'd0, 0, "R4 zero count");
    t_bad(4'd0, 1025, "R4 over max");
    t_start_wins();
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule